// File: doc/BRIEF.md
# I2S Receive Master with Sample Formatting

This block is the clock master of a two-channel serial audio link in the receive direction. It generates the bit clock and the word-select line, shifts in serial data from a device such as a MEMS microphone, and collects each frame as one left word and one right word. Each channel slot is always 32 bits wide, whatever sample width is requested. The bit rate comes from a programmable clock divider.

When a frame is complete, a byte-lane map turns it into one output beat. The beat holds a narrow (upper half of each slot) or wide (full slot) sample, for the left channel only or for both channels. The beat is presented on a valid/ready interface, with bytes in little-endian order. The output holds one beat. A frame that completes while the previous beat is still waiting is thrown away, and an overflow strobe reports the loss.

Top module: `i2s_rx_master`

## Requirements
- R1: While `rst_n` is low, `sck_o`, `ws_o`, `smp_valid`, `ovf_o`, `smp_data` and `smp_nbytes` are all zero. After reset the link starts in the low phase of left bit 0.
- R2: Each bit has a low phase followed by a high phase on `sck_o`. Each phase lasts `cfg_div`+1 clock cycles.
- R3: Number the 64 bits of a frame p = 0..63, with left bits first. `ws_o` is 1 in the low phase of bits 32..63 and in the high phase of bits 31..62, and 0 elsewhere.
- R4: `sd_i` is sampled on the clock edge that ends each high phase. The first 32 bits form the left word and the next 32 bits form the right word, each most significant bit first.
- R5: Encoding `{cfg_stereo,cfg_wide}` = 00 (mono narrow) gives `smp_data[15:0]` = left[31:16] and `smp_nbytes` = 2.
- R6: Encoding 01 (mono wide) gives `smp_data[31:0]` = left word and `smp_nbytes` = 4. The right word is discarded.
- R7: Encoding 10 (stereo narrow) gives `smp_data[15:0]` = left[31:16], `smp_data[31:16]` = right[31:16] and `smp_nbytes` = 4.
- R8: Encoding 11 (stereo wide) gives `smp_data[31:0]` = left and `smp_data[63:32]` = right, with `smp_nbytes` = 8. In every format, output byte i is `smp_data[8i+7:8i]` (little-endian, left before right), and bytes at and above `smp_nbytes` are zero.
- R9: A frame completes on the edge where `sck_o` falls after bit 63. If the output can take it, `smp_valid` and the new data appear on the next edge. A beat that is valid but not accepted keeps its data unchanged. After a handshake with no new frame, `smp_valid` drops.
- R10: A frame that completes while `smp_valid`=1 and `smp_ready`=0 is dropped, and `ovf_o` pulses for exactly one cycle on the same edge where a load would have happened. `ovf_o` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Phase length minus one, in clock cycles |
| cfg_wide | input | 1 | 1: full-slot samples, 0: upper-half samples |
| cfg_stereo | input | 1 | 1: both channels, 0: left only |
| sd_i | input | 1 | Serial data from the device |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select (0 = left slot) |
| smp_valid | output | 1 | Output beat valid |
| smp_ready | input | 1 | Sink accepts the beat |
| smp_data | output | 2*SLOT_W | Formatted sample bytes, little-endian |
| smp_nbytes | output | NB_W | Number of meaningful bytes in the beat |
| ovf_o | output | 1 | One-cycle pulse: a frame was dropped |

## Verification
The `sck_o` and `ws_o` levels change one clock after a divider tick. The bench checks their values and phase lengths on every falling clock edge, counting the clock edges since the last change. The frame-complete edge is recognised at the ports as the falling edge of `sck_o` that ends bit 63. The bench decides at that moment whether the frame will be dropped, using the valid and ready levels present then. It checks the load or the overflow pulse exactly one clock later, against expected values computed from the words it serialised. It changes the format and ready inputs only after that check, so the format in use at load time is known.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

   // encoding is {stereo, wide}
   typedef enum logic [1:0] {
      FMT_MONO_NARROW   = 2'b00,
      FMT_MONO_WIDE     = 2'b01,
      FMT_STEREO_NARROW = 2'b10,
      FMT_STEREO_WIDE   = 2'b11
   } smp_fmt_e;

   function automatic smp_fmt_e fmt_from_cfg(input logic stereo, input logic wide);
      return smp_fmt_e'({stereo, wide});
   endfunction

endpackage

// File: rtl/i2srx_tick_gen.sv
module i2srx_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   // >= keeps the period bounded when the divider is lowered mid-count
   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R2: with a non-zero divider two ticks are never adjacent
   a_r2_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && (div_i != '0)) |=> (!tick_o || (div_i == '0)));

endmodule

// File: rtl/i2srx_frame_capture.sv
module i2srx_frame_capture #(
   parameter int SLOT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sd_i,
   output logic              sck_o,
   output logic              ws_o,
   output logic              frm_valid_o,
   output logic [SLOT_W-1:0] frm_left_o,
   output logic [SLOT_W-1:0] frm_right_o
);

   localparam int FRAME_BITS = 2 * SLOT_W;
   localparam int TICKS      = 2 * FRAME_BITS;
   localparam int T_W        = $clog2(TICKS);
   localparam int B_W        = T_W - 1;

   localparam logic [B_W-1:0] LAST_LEFT   = B_W'(SLOT_W - 1);
   localparam logic [B_W-1:0] FIRST_RIGHT = B_W'(SLOT_W);
   localparam logic [B_W-1:0] LAST_RIGHT  = B_W'(FRAME_BITS - 1);
   localparam logic [T_W-1:0] LAST_TICK   = T_W'(TICKS - 1);

   logic [T_W-1:0]        t_q;
   logic [T_W-1:0]        t_nxt;
   logic [B_W-1:0]        bit_nxt;
   logic                  ws_nxt;
   logic [FRAME_BITS-2:0] sh_q;

   // tick index: bit = t[T_W-1:1], phase = t[0] (0 low, 1 high)
   always_comb begin
      t_nxt   = t_q + T_W'(1);
      bit_nxt = t_nxt[T_W-1:1];
      if (t_nxt[0]) begin
         ws_nxt = (bit_nxt >= LAST_LEFT) && (bit_nxt != LAST_RIGHT);
      end else begin
         ws_nxt = (bit_nxt >= FIRST_RIGHT);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q         <= '0;
         sck_o       <= 1'b0;
         ws_o        <= 1'b0;
         sh_q        <= '0;
         frm_valid_o <= 1'b0;
         frm_left_o  <= '0;
         frm_right_o <= '0;
      end else begin
         frm_valid_o <= 1'b0;
         if (tick_i) begin
            t_q   <= t_nxt;
            sck_o <= t_nxt[0];
            ws_o  <= ws_nxt;
            if (t_q[0]) begin
               sh_q <= {sh_q[FRAME_BITS-3:0], sd_i};
               if (t_q == LAST_TICK) begin
                  frm_valid_o                 <= 1'b1;
                  {frm_left_o, frm_right_o} <= {sh_q, sd_i};
               end
            end
         end
      end
   end

   // R2: the bit clock only moves on a divider tick
   a_r2_sck_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(sck_o));

   // R3: word select changes only together with a rising bit clock
   a_r3_ws_with_rise : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ws_o) |-> $rose(sck_o));

   // R9: a frame ends as the link re-enters the low phase of left bit 0
   a_r9_frame_at_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid_o |-> ($fell(sck_o) && !ws_o));

endmodule

// File: rtl/i2srx_fmt_map.sv
module i2srx_fmt_map
   import i2srx_pkg::*;
#(
   parameter int SLOT_W = 32,
   parameter int NB_W   = 4
) (
   input  smp_fmt_e            fmt_i,
   input  logic [SLOT_W-1:0]   left_i,
   input  logic [SLOT_W-1:0]   right_i,
   output logic [2*SLOT_W-1:0] data_o,
   output logic [NB_W-1:0]     nbytes_o
);

   localparam int SB    = SLOT_W / 8;   // bytes per slot
   localparam int NB    = SB / 2;       // bytes per narrow sample
   localparam int LANES = 2 * SB;

   // frame bytes: 0..SB-1 left (little-endian), SB..2SB-1 right
   logic [2*SLOT_W-1:0] frame_w;
   assign frame_w = {right_i, left_i};

   // source frame byte for an output lane, -1 for a zero lane
   function automatic int src_of(input smp_fmt_e f, input int lane);
      int s;
      case (f)
         FMT_MONO_NARROW:   s = (lane < NB) ? (NB + lane) : -1;
         FMT_MONO_WIDE:     s = (lane < SB) ? lane : -1;
         FMT_STEREO_NARROW: s = (lane < NB) ? (NB + lane) :
                                (lane < 2 * NB) ? (SB + lane) : -1;
         default:           s = lane;
      endcase
      return s;
   endfunction

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         int s;
         s = src_of(fmt_i, i);
         if (s < 0) begin
            lane_b = 8'h00;
         end else begin
            lane_b = frame_w[8*s +: 8];
         end
      end
      assign data_o[8*i +: 8] = lane_b;
   end

   always_comb begin
      case (fmt_i)
         FMT_MONO_NARROW: nbytes_o = NB_W'(NB);
         FMT_MONO_WIDE:   nbytes_o = NB_W'(SB);
         FMT_STEREO_NARROW: nbytes_o = NB_W'(SB);
         default:         nbytes_o = NB_W'(LANES);
      endcase
   end

endmodule

// File: rtl/i2srx_out_stage.sv
module i2srx_out_stage #(
   parameter int DATA_W = 64,
   parameter int NB_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [NB_W-1:0]   nbytes_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] out_data_o,
   output logic [NB_W-1:0]   out_nbytes_o,
   output logic              ovf_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o  <= 1'b0;
         out_data_o   <= '0;
         out_nbytes_o <= '0;
         ovf_o        <= 1'b0;
      end else begin
         ovf_o <= 1'b0;
         if (load_i && out_valid_o && !out_ready_i) begin
            ovf_o <= 1'b1;
         end else if (load_i) begin
            out_valid_o  <= 1'b1;
            out_data_o   <= data_i;
            out_nbytes_o <= nbytes_i;
         end else if (out_valid_o && out_ready_i) begin
            out_valid_o <= 1'b0;
         end
      end
   end

   // R9: a stalled beat keeps its contents
   a_r9_hold_stalled : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_nbytes_o)));

   // R10: an overflow only follows a frame arriving at a stalled output
   a_r10_ovf_cause : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> $past(load_i && out_valid_o && !out_ready_i));

   // R10: the overflow strobe lasts one cycle
   a_r10_ovf_single : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o);

endmodule

// File: rtl/i2s_rx_master.sv
module i2s_rx_master
   import i2srx_pkg::*;
#(
   parameter int SLOT_W = 32,
   parameter int DIV_W  = 8,
   parameter int NB_W   = $clog2(2 * (SLOT_W / 8) + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic                cfg_wide,
   input  logic                cfg_stereo,
   input  logic                sd_i,
   output logic                sck_o,
   output logic                ws_o,
   output logic                smp_valid,
   input  logic                smp_ready,
   output logic [2*SLOT_W-1:0] smp_data,
   output logic [NB_W-1:0]     smp_nbytes,
   output logic                ovf_o
);

   localparam int DATA_W = 2 * SLOT_W;

   if (SLOT_W < 16 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slot
      $error("SLOT_W must be a power of two of at least 16");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if ((1 << NB_W) <= DATA_W / 8) begin : g_bad_nb
      $error("NB_W too narrow for the byte count");
   end

   logic              tick;
   logic              frm_valid;
   logic [SLOT_W-1:0] frm_left;
   logic [SLOT_W-1:0] frm_right;
   logic [DATA_W-1:0] map_data;
   logic [NB_W-1:0]   map_nbytes;
   smp_fmt_e          fmt;

   assign fmt = fmt_from_cfg(cfg_stereo, cfg_wide);

   i2srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (cfg_div),
      .tick_o (tick)
   );

   i2srx_frame_capture #(.SLOT_W(SLOT_W)) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .sd_i        (sd_i),
      .sck_o       (sck_o),
      .ws_o        (ws_o),
      .frm_valid_o (frm_valid),
      .frm_left_o  (frm_left),
      .frm_right_o (frm_right)
   );

   i2srx_fmt_map #(.SLOT_W(SLOT_W), .NB_W(NB_W)) u_map (
      .fmt_i    (fmt),
      .left_i   (frm_left),
      .right_i  (frm_right),
      .data_o   (map_data),
      .nbytes_o (map_nbytes)
   );

   i2srx_out_stage #(.DATA_W(DATA_W), .NB_W(NB_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (frm_valid),
      .data_i       (map_data),
      .nbytes_i     (map_nbytes),
      .out_valid_o  (smp_valid),
      .out_ready_i  (smp_ready),
      .out_data_o   (smp_data),
      .out_nbytes_o (smp_nbytes),
      .ovf_o        (ovf_o)
   );

   // R1: nothing is reported during reset
   a_r1_quiet_after_reset : assert property (@(posedge clk)
      $past(!rst_n) |-> (!smp_valid && !ovf_o && !sck_o && !ws_o));

endmodule

// File: tb/i2s_rx_master_tb_top.sv
module i2s_rx_master_tb_top;

   localparam int SLOT_W = 32;
   localparam int DIV_W  = 8;
   localparam int NB_W   = 4;
   localparam int NF     = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             cfg_wide = 1'b0;
   logic             cfg_stereo = 1'b0;
   logic             sd_i = 1'b0;
   logic             sck_o, ws_o, smp_valid, ovf_o;
   logic             smp_ready = 1'b1;
   logic [63:0]      smp_data;
   logic [NB_W-1:0]  smp_nbytes;

   always #5 clk = ~clk;

   i2s_rx_master #(.SLOT_W(SLOT_W), .DIV_W(DIV_W), .NB_W(NB_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wide(cfg_wide),
      .cfg_stereo(cfg_stereo), .sd_i(sd_i), .sck_o(sck_o), .ws_o(ws_o),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
      .smp_nbytes(smp_nbytes), .ovf_o(ovf_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] mem_l [NF];
   logic [31:0] mem_r [NF];

   int k, hold_cnt, frames_done, pend_f, force_n, stall_pct, fmt_mode;
   bit prev_sck, pend_chk, pend_drop, pend_wide, pend_stereo;
   bit prev_valid, prev_ready;
   logic [63:0] prev_data;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_data(input logic [31:0] l, input logic [31:0] r,
                                            input bit wide, input bit stereo);
      if (!stereo && !wide) return {48'h0, l[31:16]};
      if (!stereo && wide)  return {32'h0, l};
      if (stereo && !wide)  return {32'h0, r[31:16], l[31:16]};
      return {r, l};
   endfunction

   function automatic int exp_nb(input bit wide, input bit stereo);
      return stereo ? (wide ? 8 : 4) : (wide ? 4 : 2);
   endfunction

   function automatic string fmt_req(input bit wide, input bit stereo);
      if (!stereo && !wide) return "R4 R5";
      if (!stereo && wide)  return "R4 R6";
      if (stereo && !wide)  return "R4 R7";
      return "R4 R8";
   endfunction

   // serial bit k of the stream, left word then right word, MSB first
   function automatic logic sd_bit(input int kk);
      int f, pos;
      f   = (kk / 64) % NF;
      pos = kk % 64;
      return (pos < 32) ? mem_l[f][31 - pos] : mem_r[f][63 - pos];
   endfunction

   task automatic pick_cfg();
      if (fmt_mode == 0) begin
         {cfg_stereo, cfg_wide} = 2'(frames_done % 4);
      end else begin
         {cfg_stereo, cfg_wide} = 2'($urandom % 4);
      end
      if (force_n > 0) begin
         smp_ready = 1'b0;
         force_n--;
      end else begin
         smp_ready = (($urandom % 100) >= 32'(stall_pct));
      end
   endtask

   task automatic cycle_step();
      bit exp_ws;
      int pos;
      @(negedge clk);
      if (pend_chk) begin
         // R10: drop decision made one clock earlier from valid/ready
         check(ovf_o == pend_drop, "R10 overflow strobe", 64'(ovf_o), 64'(pend_drop));
         if (!pend_drop) begin
            check(smp_valid == 1'b1, "R9 load after frame end", 64'(smp_valid), 64'd1);
            check(smp_data == exp_data(mem_l[pend_f % NF], mem_r[pend_f % NF], pend_wide, pend_stereo),
                  fmt_req(pend_wide, pend_stereo), smp_data,
                  exp_data(mem_l[pend_f % NF], mem_r[pend_f % NF], pend_wide, pend_stereo));
            check(int'(smp_nbytes) == exp_nb(pend_wide, pend_stereo),
                  "R8 byte count", 64'(smp_nbytes), 64'(exp_nb(pend_wide, pend_stereo)));
         end else begin
            check(smp_valid && smp_data == prev_data, "R10 dropped frame leaves beat",
                  smp_data, prev_data);
         end
         pend_chk = 0;
         frames_done++;
         pick_cfg();
      end else begin
         check(ovf_o == 1'b0, "R10 no spurious overflow", 64'(ovf_o), 64'd0);
         if (prev_valid && !prev_ready) begin
            check(smp_valid && smp_data == prev_data, "R9 stalled beat held", smp_data, prev_data);
         end else if (prev_valid && prev_ready) begin
            check(!smp_valid, "R9 valid drops after handshake", 64'(smp_valid), 64'd0);
         end
      end

      hold_cnt++;
      if (sck_o != prev_sck) begin
         check(hold_cnt == int'(cfg_div) + 1, "R2 phase length", 64'(hold_cnt), 64'(int'(cfg_div) + 1));
         hold_cnt = 0;
         if (prev_sck && !sck_o) begin
            k++;
            if (k % 64 == 0) begin
               pend_chk    = 1;
               pend_f      = k / 64 - 1;
               pend_drop   = smp_valid && !smp_ready;
               pend_wide   = cfg_wide;
               pend_stereo = cfg_stereo;
            end
         end
      end
      prev_sck = sck_o;

      pos = k % 64;
      exp_ws = sck_o ? (pos >= 31 && pos != 63) : (pos >= 32);
      check(ws_o == exp_ws, "R3 word select", 64'(ws_o), 64'(exp_ws));

      sd_i = sd_bit(k);
      prev_valid = smp_valid;
      prev_ready = smp_ready;
      prev_data  = smp_data;
   endtask

   task automatic run_phase(input int div, input int nframes, input int stall, input int mode, input int fn);
      for (int i = 0; i < NF; i++) begin
         mem_l[i] = $urandom;
         mem_r[i] = $urandom;
      end
      mem_l[0] = 32'h8000_0001; mem_r[0] = 32'h7FFF_FFFE;
      mem_l[1] = 32'hFFFF_0000; mem_r[1] = 32'h0000_FFFF;
      stall_pct = stall;
      fmt_mode  = mode;
      force_n   = fn;
      frames_done = 0;
      @(negedge clk);
      rst_n = 1'b0;
      cfg_div = DIV_W'(div);
      smp_ready = 1'b1;
      {cfg_stereo, cfg_wide} = 2'b00;
      repeat (3) @(negedge clk);
      // R1: outputs idle while reset is held
      check(!sck_o && !ws_o, "R1 link idle in reset", {62'h0, sck_o, ws_o}, 64'h0);
      check(!smp_valid && !ovf_o, "R1 output idle in reset", {62'h0, smp_valid, ovf_o}, 64'h0);
      check(smp_data == 64'h0 && smp_nbytes == '0, "R1 data cleared", smp_data, 64'h0);
      k = 0; hold_cnt = 0; prev_sck = 0; pend_chk = 0;
      prev_valid = 0; prev_ready = 1; prev_data = '0;
      sd_i = sd_bit(0);
      pick_cfg();
      rst_n = 1'b1;
      while (frames_done < nframes) cycle_step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      run_phase(1, 12, 0, 0, 0);    // all four formats in turn
      run_phase(0, 12, 25, 1, 0);   // fastest rate, random formats
      run_phase(3, 8, 30, 1, 0);
      run_phase(2, 10, 40, 1, 3);   // directed stalls force drops (R10)
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", frames_done, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule